// File: doc/BRIEF.md
# Write-Protected BCD Calendar Real-Time Clock

This peripheral keeps wall-clock time and date in packed BCD and steps them forward once per second. The host reaches it over a simple 32-bit register bus with a combinational read path. A separate clock-enable input marks each period of the slow real-time clock. A two-stage divider turns those periods into one-second steps. The calendar rolls over by month length, and February is lengthened in leap years.

The calendar, the divider and the control bits are guarded by a two-key write lock. New values may only be loaded while the counters are frozen through a request/acknowledge handshake. The host reads time and date from shadow copies. These copies are refreshed on every real-time-clock period outside init mode. A resync flag tells software when, after it has cleared the flag, the copies are current again.

Top module: `cal_rtc`

## Requirements
- R1: After reset, time (0x00), date (0x04), status (0x0C) and control (0x18) read 0, the divider register (0x10) reads 0x007F00FF, and the block is locked.
- R2: Writing 0xCA and then 0x53 to the key register (0x24) unlocks the block. Any other key write, at any point, returns it to locked.
- R3: While locked, writes to status, control, time, date and divider have no effect.
- R4: Status bit 7 (INIT) requests init mode. Bit 6 (INITF) rises on the first tick after INIT is set and falls in the same cycle INIT is written to 0. Time, date and divider writes are accepted only while INITF is 1.
- R5: While INITF is 1 the divider and calendar do not advance.
- R6: The divider register holds A in bits 22:16 and S in bits 14:0. One second elapses every (A+1)*(S+1) ticks, counted from the exit of init mode.
- R7: Time holds BCD seconds in bits 6:0, minutes in 14:8 and hours in 21:16. Seconds and minutes wrap from 59 to 00, hours from 23 to 00, and tens digits carry in BCD.
- R8: Date holds BCD day in bits 5:0 and month in 12:8. April, June, September and November have 30 days, February has 28, and February has 29 when the BCD year in bits 23:16 is divisible by 4. The other months have 31 days.
- R9: December rolls to month 01 and increments the year, with 99 wrapping to 00. The weekday in date bits 15:13 steps from 7 to 1 at each day change.
- R10: Status bit 5 (RSF) is cleared by writing 0 to it and is set again on the second tick after that outside init mode. Time and date reads return shadow copies, loaded on each tick outside init mode with the value the calendar holds after that tick.
- R11: Status bit 4 (INITS) reads 1 exactly when the year is nonzero.
- R12: Control bit 6 (hour format, 0 = 24-hour) is stored and read back. The other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and logic clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rtc_tick_i | input | 1 | One-cycle enable per real-time-clock period |
| reg_addr_i | input | 8 | Byte address of the register |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |

## Verification
Register writes take effect at the clock edge that samples the strobe, so the next read cycle shows them. The one exception is INITF: it needs one tick after INIT is set. Calendar results are due at the edge that samples the last tick of a second, and the shadow copy updates at that same edge. RSF rises on the edge of the second tick after it is cleared. The driver pushes each expected value into a queue as it issues a read. The monitor compares at the falling edge inside that read cycle, after all the ticks and writes that produce the value have been applied.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [7:0] ADDR_TIME = 8'h00;
  localparam logic [7:0] ADDR_DATE = 8'h04;
  localparam logic [7:0] ADDR_STAT = 8'h0C;
  localparam logic [7:0] ADDR_DIV  = 8'h10;
  localparam logic [7:0] ADDR_CTRL = 8'h18;
  localparam logic [7:0] ADDR_KEY  = 8'h24;
  localparam logic [7:0] KEY_FIRST  = 8'hCA;
  localparam logic [7:0] KEY_SECOND = 8'h53;

  typedef struct packed {
    logic [7:0] year;
    logic [2:0] wday;
    logic [7:0] month;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_t;

  function automatic logic [7:0] bcd_inc(logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic leap_year(logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] last_day(logic [7:0] m, logic [7:0] y);
    case (m)
      8'h02: return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  function automatic logic [31:0] pack_time(cal_t c);
    return {10'd0, c.hour[5:0], 1'b0, c.min[6:0], 1'b0, c.sec[6:0]};
  endfunction

  function automatic logic [31:0] pack_date(cal_t c);
    return {8'd0, c.year, c.wday, c.month[4:0], 2'd0, c.day[5:0]};
  endfunction
endpackage

// File: rtl/rtc_wprot.sv
module rtc_wprot
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_we_i,
  input  logic [7:0] key_i,
  output logic       unlocked_o
);
  typedef enum logic [1:0] {LOCKED, HALF, OPEN} kst_e;
  kst_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= LOCKED;
    else if (key_we_i) begin
      if (key_i == KEY_FIRST) st_q <= HALF;
      else if (key_i == KEY_SECOND && st_q == HALF) st_q <= OPEN;
      else st_q <= LOCKED;
    end
  end

  assign unlocked_o = (st_q == OPEN);

  AST_UNLOCK_KEYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> $past(key_we_i && key_i == KEY_SECOND)); // R2
  AST_BAD_KEY_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_we_i && key_i != KEY_FIRST && key_i != KEY_SECOND |=> !unlocked_o); // R2
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int AW = 7,
  parameter int SW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          freeze_i,
  input  logic [AW-1:0] div_a_i,
  input  logic [SW-1:0] div_s_i,
  output logic          sec_o
);
  logic [AW-1:0] cnt_a_q;
  logic [SW-1:0] cnt_s_q;
  logic wrap_a, wrap_s;

  assign wrap_a = (cnt_a_q == div_a_i);
  assign wrap_s = (cnt_s_q == div_s_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_a_q <= '0;
      cnt_s_q <= '0;
    end else if (freeze_i) begin
      cnt_a_q <= '0;
      cnt_s_q <= '0;
    end else if (tick_i) begin
      if (wrap_a) begin
        cnt_a_q <= '0;
        cnt_s_q <= wrap_s ? '0 : cnt_s_q + 1'b1;
      end else begin
        cnt_a_q <= cnt_a_q + 1'b1;
      end
    end
  end

  assign sec_o = tick_i && !freeze_i && wrap_a && wrap_s;

  AST_DIV_A_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_a_q <= div_a_i); // R6
  AST_FROZEN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> cnt_a_q == '0 && cnt_s_q == '0); // R5
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        step_i,
  input  logic        load_time_i,
  input  logic        load_date_i,
  input  logic [31:0] wdata_i,
  output cal_t        cur_o,
  output cal_t        nxt_o
);
  cal_t cur_q, inc;
  logic sec_c, min_c, hour_c, day_c, mon_c;

  always_comb begin
    inc    = cur_q;
    sec_c  = (cur_q.sec == 8'h59);
    min_c  = sec_c && (cur_q.min == 8'h59);
    hour_c = min_c && (cur_q.hour == 8'h23);
    day_c  = hour_c && (cur_q.day == last_day(cur_q.month, cur_q.year));
    mon_c  = day_c && (cur_q.month == 8'h12);
    inc.sec = sec_c ? 8'h00 : bcd_inc(cur_q.sec);
    if (sec_c) inc.min = (cur_q.min == 8'h59) ? 8'h00 : bcd_inc(cur_q.min);
    if (min_c) inc.hour = (cur_q.hour == 8'h23) ? 8'h00 : bcd_inc(cur_q.hour);
    if (hour_c) begin
      inc.day  = day_c ? 8'h01 : bcd_inc(cur_q.day);
      inc.wday = (cur_q.wday == 3'd7) ? 3'd1 : cur_q.wday + 3'd1;
    end
    if (day_c) inc.month = mon_c ? 8'h01 : bcd_inc(cur_q.month);
    if (mon_c) inc.year = (cur_q.year == 8'h99) ? 8'h00 : bcd_inc(cur_q.year);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else begin
      if (load_time_i) begin
        cur_q.sec  <= {1'b0, wdata_i[6:0]};
        cur_q.min  <= {1'b0, wdata_i[14:8]};
        cur_q.hour <= {2'b0, wdata_i[21:16]};
      end else if (step_i) begin
        cur_q.sec  <= inc.sec;
        cur_q.min  <= inc.min;
        cur_q.hour <= inc.hour;
      end
      if (load_date_i) begin
        cur_q.day   <= {2'b0, wdata_i[5:0]};
        cur_q.month <= {3'b0, wdata_i[12:8]};
        cur_q.wday  <= wdata_i[15:13];
        cur_q.year  <= wdata_i[23:16];
      end else if (step_i) begin
        cur_q.day   <= inc.day;
        cur_q.month <= inc.month;
        cur_q.wday  <= inc.wday;
        cur_q.year  <= inc.year;
      end
    end
  end

  assign cur_o = cur_q;
  assign nxt_o = step_i ? inc : cur_q;

  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_time_i && cur_q.sec == 8'h59 |=> cur_q.sec == 8'h00); // R7
  AST_HOUR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_time_i && cur_q.hour == 8'h23 && cur_q.min == 8'h59 && cur_q.sec == 8'h59
    |=> cur_q.hour == 8'h00); // R7
  AST_MONTH_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_date_i && $past(1'b1) && cur_q.month == 8'h12 && cur_q.day == 8'h31 &&
    cur_q.hour == 8'h23 && cur_q.min == 8'h59 && cur_q.sec == 8'h59 |=> cur_q.month == 8'h01); // R9
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import rtc_pkg::*;
#(
  parameter int          DIV_A_W   = 7,
  parameter int          DIV_S_W   = 15,
  parameter int unsigned DIV_A_RST = 127,
  parameter int unsigned DIV_S_RST = 255
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rtc_tick_i,
  input  logic [7:0]  reg_addr_i,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o
);
  localparam int DIV_A_LSB = 16;

  logic unlocked, init_q, initf_q, rsf_q, sync_q, fmt_q, sec_pulse;
  logic wr_stat, wr_ctrl, wr_time, wr_date, wr_div, wr_key;
  logic [DIV_A_W-1:0] div_a_q;
  logic [DIV_S_W-1:0] div_s_q;
  cal_t cal_cur, cal_nxt, shd_q;

  assign wr_key  = reg_we_i && reg_addr_i == ADDR_KEY;
  assign wr_stat = reg_we_i && reg_addr_i == ADDR_STAT && unlocked;
  assign wr_ctrl = reg_we_i && reg_addr_i == ADDR_CTRL && unlocked;
  assign wr_time = reg_we_i && reg_addr_i == ADDR_TIME && unlocked && initf_q;
  assign wr_date = reg_we_i && reg_addr_i == ADDR_DATE && unlocked && initf_q;
  assign wr_div  = reg_we_i && reg_addr_i == ADDR_DIV  && unlocked && initf_q;

  rtc_wprot u_wprot (
    .clk_i, .rst_ni,
    .key_we_i  (wr_key),
    .key_i     (reg_wdata_i[7:0]),
    .unlocked_o(unlocked)
  );

  rtc_prescaler #(.AW(DIV_A_W), .SW(DIV_S_W)) u_presc (
    .clk_i, .rst_ni,
    .tick_i  (rtc_tick_i),
    .freeze_i(initf_q),
    .div_a_i (div_a_q),
    .div_s_i (div_s_q),
    .sec_o   (sec_pulse)
  );

  rtc_calendar u_cal (
    .clk_i, .rst_ni,
    .step_i     (sec_pulse),
    .load_time_i(wr_time),
    .load_date_i(wr_date),
    .wdata_i    (reg_wdata_i),
    .cur_o      (cal_cur),
    .nxt_o      (cal_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q  <= 1'b0;
      initf_q <= 1'b0;
      rsf_q   <= 1'b0;
      sync_q  <= 1'b0;
      fmt_q   <= 1'b0;
      div_a_q <= DIV_A_W'(DIV_A_RST);
      div_s_q <= DIV_S_W'(DIV_S_RST);
      shd_q   <= '0;
    end else begin
      if (wr_stat) init_q <= reg_wdata_i[7];
      // INITF follows INIT down at once, up on the next tick
      if ((wr_stat && !reg_wdata_i[7]) || !init_q) initf_q <= 1'b0;
      else if (rtc_tick_i) initf_q <= 1'b1;
      if (wr_stat && !reg_wdata_i[5]) begin
        rsf_q  <= 1'b0;
        sync_q <= 1'b0;
      end else if (rtc_tick_i && !initf_q && !rsf_q) begin
        rsf_q  <= sync_q;
        sync_q <= !sync_q;
      end
      if (wr_ctrl) fmt_q <= reg_wdata_i[6];
      if (wr_div) begin
        div_a_q <= reg_wdata_i[DIV_A_LSB +: DIV_A_W];
        div_s_q <= reg_wdata_i[DIV_S_W-1:0];
      end
      if (rtc_tick_i && !initf_q) shd_q <= cal_nxt;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      ADDR_TIME: reg_rdata_o = pack_time(shd_q);
      ADDR_DATE: reg_rdata_o = pack_date(shd_q);
      ADDR_STAT: reg_rdata_o = {24'd0, init_q, initf_q, rsf_q, cal_cur.year != 8'h00, 4'd0};
      ADDR_DIV:  reg_rdata_o = 32'(div_a_q) << DIV_A_LSB | 32'(div_s_q);
      ADDR_CTRL: reg_rdata_o = {25'd0, fmt_q, 6'd0};
      default:   reg_rdata_o = 32'd0;
    endcase
  end

  AST_INITF_NEEDS_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    initf_q |-> init_q); // R4
  AST_LOCKED_NO_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked && !init_q |=> !init_q); // R3
  AST_FROZEN_CAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    initf_q && !wr_time && !wr_date |=> $stable(cal_cur)); // R5
  AST_RSF_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsf_q) |-> $past(rtc_tick_i && !initf_q)); // R10
  AST_DIV_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !initf_q |=> $stable(div_a_q) && $stable(div_s_q)); // R4
endmodule

// File: tb/cal_rtc_tb.sv
module cal_rtc_tb;
  localparam logic [7:0] A_TIME = 8'h00, A_DATE = 8'h04, A_STAT = 8'h0C,
                         A_DIV = 8'h10, A_CTRL = 8'h18, A_KEY = 8'h24;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0, rd_req = 1'b0, done = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  cal_rtc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rtc_tick_i(tick),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  // monitor: pops the expected item for each read cycle
  always @(negedge clk) begin
    if (rd_req && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] e, input string t);
    addr = a; exp_q.push_back(e); tag_q.push_back(t); rd_req = 1'b1;
    @(posedge clk); #1 rd_req = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick = 1'b0;
  endtask

  task automatic unlock();
    wr(A_KEY, 32'hCA); wr(A_KEY, 32'h53);
  endtask

  task automatic set_cal(input logic [31:0] t, input logic [31:0] d);
    unlock(); wr(A_STAT, 32'hA0); ticks(1);
    wr(A_TIME, t); wr(A_DATE, d);
    wr(A_STAT, 32'h20); wr(A_KEY, 32'hFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk(A_TIME, 32'h0, "R1 time");
    chk(A_DATE, 32'h0, "R1 date");
    chk(A_DIV, 32'h007F00FF, "R1 divider");
    chk(A_CTRL, 32'h0, "R1 control");
    chk(A_STAT, 32'h0, "R1 status");
    ticks(3);
    chk(A_STAT, 32'h20, "R10 rsf after reset");
    // locked writes
    wr(A_STAT, 32'h80);
    chk(A_STAT, 32'h20, "R3 init locked");
    wr(A_CTRL, 32'h40);
    chk(A_CTRL, 32'h0, "R3 ctrl locked");
    // broken key sequence
    wr(A_KEY, 32'hCA); wr(A_KEY, 32'h12); wr(A_KEY, 32'h53);
    wr(A_STAT, 32'hA0);
    chk(A_STAT, 32'h20, "R2 wrong key");
    // init handshake
    unlock();
    wr(A_STAT, 32'hA0);
    chk(A_STAT, 32'hA0, "R4 initf waits tick");
    wr(A_DIV, 32'h0);
    chk(A_DIV, 32'h007F00FF, "R4 div before initf");
    ticks(1);
    chk(A_STAT, 32'hE0, "R4 initf set");
    wr(A_DIV, 32'h0);
    chk(A_DIV, 32'h0, "R6 div load");
    wr(A_TIME, 32'h00235958);
    wr(A_DATE, 32'h0024E228);
    chk(A_STAT, 32'hF0, "R11 inits set");
    ticks(3);
    chk(A_TIME, 32'h0, "R10 shadow held in init");
    wr(A_CTRL, 32'h40);
    chk(A_CTRL, 32'h40, "R12 fmt bit");
    wr(A_STAT, 32'h00);
    chk(A_STAT, 32'h10, "R4 exit clears initf");
    ticks(1);
    chk(A_STAT, 32'h10, "R10 rsf one tick");
    chk(A_TIME, 32'h00235959, "R5 no advance while frozen");
    ticks(1);
    chk(A_STAT, 32'h30, "R10 rsf second tick");
    chk(A_TIME, 32'h0, "R7 midnight");
    chk(A_DATE, 32'h00242229, "R8 leap feb 29 R9 wday");
    wr(A_KEY, 32'hFF);
    wr(A_STAT, 32'h80);
    chk(A_STAT, 32'h30, "R3 relocked status");
    wr(A_CTRL, 32'h0);
    chk(A_CTRL, 32'h40, "R3 relocked ctrl");
    set_cal(32'h00235959, 32'h00246229); ticks(1);
    chk(A_DATE, 32'h00248301, "R8 leap feb end");
    set_cal(32'h00235959, 32'h00234228); ticks(1);
    chk(A_DATE, 32'h00236301, "R8 plain feb end");
    set_cal(32'h00235959, 32'h0099F231); ticks(1);
    chk(A_TIME, 32'h0, "R7 year end time");
    chk(A_DATE, 32'h00002101, "R9 year wrap");
    chk(A_STAT, 32'h20, "R11 inits clear");
    set_cal(32'h00235959, 32'h0025A430); ticks(1);
    chk(A_DATE, 32'h0025C501, "R8 30 day month");
    set_cal(32'h00095958, 32'h00012101); ticks(1);
    chk(A_TIME, 32'h00095959, "R7 seconds step");
    ticks(1);
    chk(A_TIME, 32'h00100000, "R7 bcd hour carry");
    // divider (A=1,S=2): six ticks per second
    unlock(); wr(A_STAT, 32'hA0); ticks(1);
    wr(A_DIV, 32'h00010002); wr(A_TIME, 32'h0);
    wr(A_STAT, 32'h20); wr(A_KEY, 32'hFF);
    ticks(5);
    chk(A_TIME, 32'h0, "R6 five ticks");
    ticks(1);
    chk(A_TIME, 32'h00000001, "R6 sixth tick");
    ticks(6);
    chk(A_TIME, 32'h00000002, "R6 next second");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule